// File: doc/BRIEF.md
# Serial Configuration Bit ROM

This block models the control side of a one-time-programmable serial memory that feeds a configuration bitstream to a programmable logic device, one bit per clock. A bit-address counter indexes a read-only array whose contents are computed at elaboration. The loading device supplies the clock. It holds the counter at zero through a combined reset/output-enable pin, and it parks the memory through an active-low chip-enable once the load is finished.

The reset/output-enable pin has a polarity chosen by parameter. At its active level it clears the counter and turns the data output off. At its other level it lets the output drive. The counter stops at a terminal count and does not wrap. If the pin is never taken to its reset level between loads, the counter keeps its position, so several bitstreams can be stored end to end and read one after another. All outputs are registered. A separate enable output stands for the tri-state control of the data line, and a standby flag reports that the chip-enable is off.

Top module: `cfg_bitrom`

## Requirements
- R1: While `rst` is high at a clock edge, the counter goes to address 0. After the edge, `dout_en` and `dout` read 0 and `standby` reads 1.
- R2: The pin is inactive when its level differs from `RST_ACTIVE_HIGH`. At each rising edge where `chip_en_n` is 0 and the pin is inactive, the counter advances by one and `dout_en` reads 1. The bit then on `dout` is the array bit at the address held before that edge. Array bit a equals the XOR-reduction of (a AND `KEY`).
- R3: At a rising edge where the pin is at its active level, the counter is set to 0 and `dout_en` reads 0 afterwards. The first enabled edge after release presents bit 0.
- R4: With `RST_ACTIVE_HIGH`=1 a high pin level resets the counter. With 0 a low level resets it, and the behaviour is otherwise identical.
- R5: Once the counter holds address `TC`, further enabled edges leave it there, and `dout` keeps presenting bit `TC`.
- R6: At an edge where `chip_en_n` is 1 and the pin is inactive, `standby` reads 1 and `dout_en` reads 0 afterwards, and the counter keeps its value.
- R7: At an edge where `chip_en_n` is 1 and the pin is active, the counter is set to 0. The next enabled edge presents bit 0.
- R8: After a pause in standby without a reset, the next enabled edge presents the bit at the address where the stream stopped.
- R9: Whenever `dout_en` is 0, `dout` is 0.
- R10: `standby` and `dout_en` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the loading device |
| rst | input | 1 | Synchronous active-high power-on reset |
| chip_en_n | input | 1 | Active-low chip enable; high selects standby |
| rst_oe | input | 1 | Counter reset / output enable, polarity set by `RST_ACTIVE_HIGH` |
| dout | output | 1 | Serial data bit, 0 while not driven |
| dout_en | output | 1 | High while the data line is driven |
| standby | output | 1 | High after an edge with the chip enable off |

## Verification
The assertions assume that `chip_en_n` and `rst_oe` are stable around each rising edge and are sampled only there. They also assume that the counter sees `TC` below `DEPTH`. The stimulus changes both pins only on falling edges and uses a terminal count well inside the array. Two copies of the block run side by side with opposite reset polarities. Each copy gets the reset pin driven at its own active level, so both must give the same output stream. The pin sequences cover a long run into saturation, standby pauses with and without the reset level, and a reset in the middle of a stream.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

  // Decoded control pins, one bundle shared by counter and output stage
  typedef struct packed {
    logic pin_reset;  // reset/output-enable pin at its reset level
    logic chip_on;    // chip enable asserted
  } ctl_t;

  // Stored content: parity of the address bits selected by the key
  function automatic logic pattern_bit(input int unsigned a, input int unsigned key);
    return ^(a & key);
  endfunction

endpackage

// File: rtl/cfgrom_ctl.sv
module cfgrom_ctl
  import cfgrom_pkg::*;
#(
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic chip_en_n,
  input  logic rst_oe,
  output ctl_t ctl
);

  logic hit;

  generate
    if (RST_ACTIVE_HIGH) begin : g_high
      assign hit = rst_oe;
    end else begin : g_low
      assign hit = ~rst_oe;
    end
  endgenerate

  assign ctl.pin_reset = hit;
  assign ctl.chip_on   = ~chip_en_n;

endmodule

// File: rtl/cfgrom_addr_ctr.sv
module cfgrom_addr_ctr
  import cfgrom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int TC     = 63
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  output logic [ADDR_W-1:0] addr_q
);

  localparam logic [ADDR_W-1:0] TC_A = ADDR_W'(TC);

  logic at_end;
  assign at_end = (addr_q == TC_A);

  always_ff @(posedge clk) begin
    if (rst || ctl.pin_reset) begin
      addr_q <= '0;
    end else if (ctl.chip_on && !at_end) begin
      addr_q <= addr_q + 1'b1;
    end
  end

endmodule

// File: rtl/cfgrom_array.sv
module cfgrom_array
  import cfgrom_pkg::*;
#(
  parameter int          DEPTH  = 64,
  parameter int          ADDR_W = 6,
  parameter int unsigned KEY    = 32'h2D
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_q
);

  logic mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = pattern_bit(unsigned'(i), KEY);
    end
  end

  // Registered read, no reset, so a block RAM can hold the array
  always_ff @(posedge clk) begin
    rd_q <= mem[addr];
  end

endmodule

// File: rtl/cfgrom_outreg.sv
module cfgrom_outreg
  import cfgrom_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctl_t ctl,
  input  logic rd_q,
  output logic dout,
  output logic dout_en,
  output logic standby
);

  logic drive_q;
  logic stby_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
      stby_q  <= 1'b1;
    end else begin
      drive_q <= ctl.chip_on && !ctl.pin_reset;
      stby_q  <= !ctl.chip_on;
    end
  end

  assign dout    = rd_q & drive_q;
  assign dout_en = drive_q;
  assign standby = stby_q;

endmodule

// File: rtl/cfg_bitrom.sv
module cfg_bitrom
  import cfgrom_pkg::*;
#(
  parameter int          DEPTH           = 64,
  parameter int          TC              = DEPTH - 1,
  parameter int unsigned KEY             = 32'h2D,
  parameter bit          RST_ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic chip_en_n,
  input  logic rst_oe,
  output logic dout,
  output logic dout_en,
  output logic standby
);

  localparam int ADDR_W = $clog2(DEPTH);

  ctl_t              ctl;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;

  cfgrom_ctl #(
    .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
  ) u_ctl (
    .chip_en_n(chip_en_n),
    .rst_oe   (rst_oe),
    .ctl      (ctl)
  );

  cfgrom_addr_ctr #(
    .ADDR_W(ADDR_W),
    .TC    (TC)
  ) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ctl),
    .addr_q(addr_q)
  );

  cfgrom_array #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .KEY   (KEY)
  ) u_rom (
    .clk (clk),
    .addr(addr_q),
    .rd_q(rd_q)
  );

  cfgrom_outreg u_out (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .rd_q   (rd_q),
    .dout   (dout),
    .dout_en(dout_en),
    .standby(standby)
  );

endmodule

// File: rtl/cfg_bitrom_chk.sv
module cfg_bitrom_chk #(
  parameter int ADDR_W          = 6,
  parameter int TC              = 63,
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              chip_en_n,
  input logic              rst_oe,
  input logic              dout_en,
  input logic              standby,
  input logic [ADDR_W-1:0] addr_q
);

  localparam logic [ADDR_W-1:0] TC_A = ADDR_W'(TC);

  logic pin_rst;
  assign pin_rst = (rst_oe == RST_ACTIVE_HIGH);

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!chip_en_n && !pin_rst && addr_q != TC_A) |=> (addr_q == $past(addr_q) + 1'b1) && dout_en);

  a_r3_pin_clears: assert property (@(posedge clk) disable iff (rst)
    pin_rst |=> (addr_q == '0) && !dout_en);

  a_r5_saturate: assert property (@(posedge clk) disable iff (rst)
    (addr_q == TC_A && !pin_rst) |=> addr_q == TC_A);

  a_r6_standby_hold: assert property (@(posedge clk) disable iff (rst)
    (chip_en_n && !pin_rst) |=> standby && !dout_en && $stable(addr_q));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(standby && dout_en));

endmodule

bind cfg_bitrom cfg_bitrom_chk #(
  .ADDR_W         ($clog2(DEPTH)),
  .TC             (TC),
  .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .chip_en_n(chip_en_n),
  .rst_oe   (rst_oe),
  .dout_en  (dout_en),
  .standby  (standby),
  .addr_q   (addr_q)
);

// File: tb/sim_cfg_bitrom.sv
`timescale 1ns/1ps
module sim_cfg_bitrom;

  localparam int CLK_P = 10;
  localparam int DEPTH = 64;
  localparam int TC    = 40;
  localparam int KEYV  = 45;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1;
  logic pin_hi = 1'b0;
  logic pin_lo = 1'b1;
  logic d0, e0, s0, d1, e1, s1;

  int total = 0;
  int bad = 0;
  int m_addr = 0;
  bit done = 0;

  logic [2:0] q_val[$];
  string      q_tag[$];

  always #(CLK_P/2) clk = ~clk;

  cfg_bitrom #(.DEPTH(DEPTH), .TC(TC), .KEY(KEYV), .RST_ACTIVE_HIGH(1'b1)) u0 (
    .clk(clk), .rst(rst), .chip_en_n(ce_n), .rst_oe(pin_hi),
    .dout(d0), .dout_en(e0), .standby(s0));

  cfg_bitrom #(.DEPTH(DEPTH), .TC(TC), .KEY(KEYV), .RST_ACTIVE_HIGH(1'b0)) u1 (
    .clk(clk), .rst(rst), .chip_en_n(ce_n), .rst_oe(pin_lo),
    .dout(d1), .dout_en(e1), .standby(s1));

  function automatic logic ref_bit(input int a);
    return ^(a & KEYV);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of pin levels and queue the expected outputs
  task automatic step(input logic ce_on, input logic rpin, input string tag);
    logic en_x, d_x, sb_x;
    string t;
    @(negedge clk);
    ce_n   = !ce_on;
    pin_hi = rpin;
    pin_lo = !rpin;
    en_x = ce_on && !rpin;
    d_x  = en_x ? ref_bit(m_addr) : 1'b0;
    sb_x = !ce_on;
    if (tag != "") t = tag;
    else if (!ce_on) t = "R6";
    else if (rpin) t = "R3";
    else if (m_addr == TC) t = "R5";
    else t = "R2";
    q_val.push_back({en_x, d_x, sb_x});
    q_tag.push_back(t);
    if (rpin) m_addr = 0;
    else if (ce_on && m_addr != TC) m_addr++;
  endtask

  // Monitor: compare each queued expectation after its clock edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (q_val.size() > 0) begin
      logic [2:0] v;
      string t;
      v = q_val.pop_front();
      t = q_tag.pop_front();
      check(t, e0, v[2], "u0 dout_en");
      check(t, d0, v[1], "u0 dout");
      check(t, s0, v[0], "u0 standby");
      check({t, "/R4"}, e1, v[2], "u1 dout_en");
      check({t, "/R4"}, d1, v[1], "u1 dout");
      check({t, "/R4"}, s1, v[0], "u1 standby");
      if (!e0) check("R9", d0, 1'b0, "u0 dout while off");
      check("R10", s0 && e0, 1'b0, "u0 standby with drive");
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", e0, 1'b0, "dout_en in reset");
    check("R1", d0, 1'b0, "dout in reset");
    check("R1", s0, 1'b1, "standby in reset");
    check("R1", e1, 1'b0, "u1 dout_en in reset");
    rst = 1'b0;
    m_addr = 0;

    // R3: pin at reset level with chip on
    for (int i = 0; i < 2; i++) step(1'b1, 1'b1, "R3");
    // R2: stream from address 0
    for (int i = 0; i < 15; i++) step(1'b1, 1'b0, "");
    // R6: standby pause
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R6");
    // R8: resume without reset
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R8");
    // R5: run past terminal count
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, "");
    // R7: standby with reset level, then restart at bit 0
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, "R7");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R7");
    // R3: reset pulse mid-stream
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "");
    step(1'b1, 1'b1, "R3");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R3");
    step(1'b0, 1'b0, "R6");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule